// File: doc/BRIEF.md
# Atomic read-modify-write unit

This unit carries out the atomic store-class instructions of a packet-filter virtual machine against one memory port. On a start strobe it captures the instruction's opcode and immediate, the destination, source and R0 register values, and a signed 16-bit offset. It forms the address as the destination value plus the sign-extended offset. It then reads the addressed word or double word and combines it with the source operand. It writes the result back unless a compare-exchange finds a mismatch. The memory port stays locked from the read request until the write has been accepted, so no other agent can get between the read and the write.

When the unit finishes it raises `done` for exactly one cycle. In that cycle it reports any fault and, when the instruction fetches, the old memory value and which register takes it: the source register, or R0 for compare-exchange. The immediate selects the operation. Bit 0 of the immediate is the fetch modifier, which is optional on the simple operations and required on exchange and compare-exchange. A malformed encoding or an address that does not match the operand size ends the instruction at once with no memory traffic.

The memory port moves one 64-bit line per transfer. A transfer completes in a cycle where `mem_req` and `mem_ready` are both high. Read data is taken in that same cycle.

Top module: `atomic_rmw_unit`

## Requirements
- R1: The unit accepts an opcode only when bits [2:0] equal 3 (store from register) and bits [7:5] equal 6 (atomic). Bits [4:3] must be 00, giving a 32-bit operation (opcode 0xC3), or 11, giving a 64-bit operation (opcode 0xDB). Any other opcode, including sizes 01 and 10, raises `illegal` with `done` and produces no memory transfer and no writeback.
- R2: Immediate 0x00 adds, 0x40 ORs, 0x50 ANDs and 0xA0 XORs the source operand into memory at dst plus the sign-extended 16-bit offset. The arithmetic wraps at the operand width.
- R3: When immediate bit 0 is set, `wb_en` is high with `done` and `wb_data` carries the old memory value, with `wb_to_r0` low for every operation except compare-exchange. When bit 0 is clear, `wb_en` stays low.
- R4: Immediate 0xE1 (exchange) stores the source operand and returns the old value for the source register.
- R5: Immediate 0xF1 (compare-exchange) compares the old value with R0. It stores the source operand only on a match and performs no write on a mismatch. In both cases it returns the zero-extended old value with `wb_to_r0` high.
- R6: Any immediate outside {0x00, 0x01, 0x40, 0x41, 0x50, 0x51, 0xA0, 0xA1, 0xE1, 0xF1}, including one with any bit of [31:8] set, raises `illegal` with no memory transfer.
- R7: On an otherwise legal instruction, an address whose low two bits (32-bit) or low three bits (64-bit) are not zero raises `misaligned` with no memory transfer. `illegal` takes precedence, so the two flags are never high together.
- R8: A 32-bit operation works on the low 32 bits of the source and R0 values and zero-extends the fetched value. It uses byte strobes 0x0F when address bit 2 is 0 and 0xF0 when it is 1. The other half of the line is left unchanged. A 64-bit operation uses strobes 0xFF.
- R9: `mem_lock` is high on every cycle from the read request until the cycle in which the write is accepted, or until the compute cycle when no write follows. `mem_req` is never high without `mem_lock`.
- R10: Each legal instruction makes exactly one read and at most one write. It holds `mem_req`, `mem_addr` and `mem_we` steady while waiting for `mem_ready`, and raises `done` for one cycle in the cycle after the last transfer or compute step.
- R11: After synchronous reset, `done`, `mem_req`, `mem_lock` and `wb_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction; sampled only while idle |
| op_code | input | 8 | Instruction opcode byte |
| imm_val | input | 32 | Immediate field selecting the operation |
| offset_val | input | 16 | Signed address offset |
| dst_val | input | 64 | Destination register value (base address) |
| src_val | input | 64 | Source register value (operand) |
| r0_val | input | 64 | R0 value (compare-exchange comparand) |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 64 | Write line |
| mem_be | output | 8 | Byte strobes |
| mem_rdata | input | 64 | Read line, valid with mem_ready |
| mem_ready | input | 1 | Transfer accepted this cycle |
| mem_lock | output | 1 | Port held for the read-modify-write |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Unsupported encoding, valid with done |
| misaligned | output | 1 | Address not size-aligned, valid with done |
| wb_en | output | 1 | Fetched value to be written back |
| wb_to_r0 | output | 1 | Writeback goes to R0 instead of the source register |
| wb_data | output | 64 | Fetched old memory value |

## Verification
A wrong decode or a stale captured field shows up at the memory port within two cycles of the start strobe, either as traffic on a faulting instruction or as the wrong address or strobes. A corrupted old-value register or operation select shows up in the line written back, which the bench reads from its memory model once `done` arrives. It also shows up in `wb_data` in the same cycle. A sequencer stuck in the wrong state shows up as a lock that drops early, a second read, a missing write on a compare-exchange match or a write on a mismatch, or a `done` that lasts two cycles. All of these are visible before the next instruction starts.

// File: rtl/amo_pkg.sv
package amo_pkg;

    localparam int XLEN  = 64;
    localparam int HALF  = XLEN / 2;
    localparam int NBYTE = XLEN / 8;

    localparam logic [2:0] CLASS_STORE_REG = 3'h3;
    localparam logic [2:0] MODE_ATOMIC     = 3'h6;
    localparam logic [1:0] SIZE_W32        = 2'b00;
    localparam logic [1:0] SIZE_W64        = 2'b11;

    typedef enum logic [2:0] {
        K_ADD, K_OR, K_AND, K_XOR, K_SWAP, K_CAS
    } amo_kind_e;

    typedef struct packed {
        amo_kind_e kind;
        logic      fetch;
        logic      wide;
        logic      bad;
    } amo_dec_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_READ, ST_CALC, ST_WRITE, ST_DONE
    } amo_state_e;

    function automatic amo_dec_t amo_decode_f(input logic [7:0] opc, input logic [31:0] imm);
        amo_dec_t d;
        d.kind  = K_ADD;
        d.fetch = imm[0];
        d.wide  = (opc[4:3] == SIZE_W64);
        d.bad   = 1'b0;
        if (opc[2:0] != CLASS_STORE_REG || opc[7:5] != MODE_ATOMIC)
            d.bad = 1'b1;
        if (opc[4:3] != SIZE_W32 && opc[4:3] != SIZE_W64)
            d.bad = 1'b1;
        if (imm[31:8] != '0 || imm[3:1] != '0)
            d.bad = 1'b1;
        case (imm[7:4])
            4'h0: d.kind = K_ADD;
            4'h4: d.kind = K_OR;
            4'h5: d.kind = K_AND;
            4'ha: d.kind = K_XOR;
            4'he: begin d.kind = K_SWAP; if (!imm[0]) d.bad = 1'b1; end
            4'hf: begin d.kind = K_CAS;  if (!imm[0]) d.bad = 1'b1; end
            default: d.bad = 1'b1;
        endcase
        return d;
    endfunction

    function automatic logic [XLEN-1:0] amo_apply_f(input amo_kind_e kind,
                                                    input logic [XLEN-1:0] mem_v,
                                                    input logic [XLEN-1:0] opnd);
        case (kind)
            K_ADD:   return mem_v + opnd;
            K_OR:    return mem_v | opnd;
            K_AND:   return mem_v & opnd;
            K_XOR:   return mem_v ^ opnd;
            default: return opnd;
        endcase
    endfunction

endpackage

// File: rtl/amo_front.sv
module amo_front
    import amo_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [7:0]        op_code,
    input  logic [31:0]       imm_val,
    input  logic [15:0]       offset_val,
    input  logic [ADDR_W-1:0] base,
    output amo_dec_t          dec,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              unaligned
);
    localparam int EXT_W = ADDR_W - 16;

    assign dec       = amo_decode_f(op_code, imm_val);
    assign eff_addr  = base + {{EXT_W{offset_val[15]}}, offset_val};
    assign unaligned = dec.wide ? (eff_addr[2:0] != 3'b000) : (eff_addr[1:0] != 2'b00);
endmodule

// File: rtl/amo_datapath.sv
module amo_datapath
    import amo_pkg::*;
(
    input  amo_kind_e         kind,
    input  logic              wide,
    input  logic              lane_hi,
    input  logic [XLEN-1:0]   old_line,
    input  logic [XLEN-1:0]   opnd,
    input  logic [XLEN-1:0]   cmp_val,
    output logic [XLEN-1:0]   new_line,
    output logic [NBYTE-1:0]  strobe,
    output logic              need_wr,
    output logic [XLEN-1:0]   old_val
);
    logic [HALF-1:0] old_half;
    logic [XLEN-1:0] result;
    logic            match;

    assign old_half = lane_hi ? old_line[XLEN-1:HALF] : old_line[HALF-1:0];
    assign old_val  = wide ? old_line : {{HALF{1'b0}}, old_half};
    assign result   = amo_apply_f(kind, old_val, opnd);
    assign match    = wide ? (old_line == cmp_val) : (old_half == cmp_val[HALF-1:0]);
    assign need_wr  = (kind != K_CAS) || match;
    assign new_line = wide ? result : {result[HALF-1:0], result[HALF-1:0]};

    for (genvar g = 0; g < NBYTE; g++) begin : g_strobe
        assign strobe[g] = wide | (lane_hi == (g >= NBYTE / 2));
    end
endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
    import amo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic fault,
    input  logic ready,
    input  logic need_wr,
    output logic cap_op,
    output logic cap_rd,
    output logic req,
    output logic we,
    output logic lock,
    output logic fin
);
    amo_state_e st, st_nx;

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE:  if (start) st_nx = fault ? ST_DONE : ST_READ;
            ST_READ:  if (ready) st_nx = ST_CALC;
            ST_CALC:  st_nx = need_wr ? ST_WRITE : ST_DONE;
            ST_WRITE: if (ready) st_nx = ST_DONE;
            ST_DONE:  st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    assign cap_op = (st == ST_IDLE) && start;
    assign cap_rd = (st == ST_READ) && ready;
    assign req    = (st == ST_READ) || (st == ST_WRITE);
    assign we     = (st == ST_WRITE);
    assign lock   = (st == ST_READ) || (st == ST_CALC) || (st == ST_WRITE);
    assign fin    = (st == ST_DONE);
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
    import amo_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        op_code,
    input  logic [31:0]       imm_val,
    input  logic [15:0]       offset_val,
    input  logic [XLEN-1:0]   dst_val,
    input  logic [XLEN-1:0]   src_val,
    input  logic [XLEN-1:0]   r0_val,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    output logic [NBYTE-1:0]  mem_be,
    input  logic [XLEN-1:0]   mem_rdata,
    input  logic              mem_ready,
    output logic              mem_lock,
    output logic              done,
    output logic              illegal,
    output logic              misaligned,
    output logic              wb_en,
    output logic              wb_to_r0,
    output logic [XLEN-1:0]   wb_data
);
    amo_dec_t          dec;
    logic [ADDR_W-1:0] eff_addr;
    logic              unaligned;

    amo_kind_e         kind_q;
    logic              wide_q, fetch_q, illegal_q, misal_q;
    logic [ADDR_W-1:0] addr_q;
    logic [XLEN-1:0]   src_q, r0_q, old_q;

    logic              cap_op, cap_rd, req, we, lock, fin;
    logic [XLEN-1:0]   new_line, old_val;
    logic [NBYTE-1:0]  strobe;
    logic              need_wr;

    amo_front #(.ADDR_W(ADDR_W)) front_i (
        .op_code    (op_code),
        .imm_val    (imm_val),
        .offset_val (offset_val),
        .base       (dst_val[ADDR_W-1:0]),
        .dec        (dec),
        .eff_addr   (eff_addr),
        .unaligned  (unaligned)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q    <= K_ADD;
            wide_q    <= 1'b0;
            fetch_q   <= 1'b0;
            illegal_q <= 1'b0;
            misal_q   <= 1'b0;
            addr_q    <= '0;
            src_q     <= '0;
            r0_q      <= '0;
            old_q     <= '0;
        end else begin
            if (cap_op) begin
                kind_q    <= dec.kind;
                wide_q    <= dec.wide;
                fetch_q   <= dec.fetch;
                illegal_q <= dec.bad;
                misal_q   <= !dec.bad && unaligned;
                addr_q    <= eff_addr;
                src_q     <= src_val;
                r0_q      <= r0_val;
            end
            if (cap_rd)
                old_q <= mem_rdata;
        end
    end

    amo_datapath dp_i (
        .kind     (kind_q),
        .wide     (wide_q),
        .lane_hi  (addr_q[2]),
        .old_line (old_q),
        .opnd     (src_q),
        .cmp_val  (r0_q),
        .new_line (new_line),
        .strobe   (strobe),
        .need_wr  (need_wr),
        .old_val  (old_val)
    );

    amo_ctrl ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .fault   (dec.bad || unaligned),
        .ready   (mem_ready),
        .need_wr (need_wr),
        .cap_op  (cap_op),
        .cap_rd  (cap_rd),
        .req     (req),
        .we      (we),
        .lock    (lock),
        .fin     (fin)
    );

    assign mem_req    = req;
    assign mem_we     = we;
    assign mem_addr   = addr_q;
    assign mem_wdata  = we ? new_line : '0;
    assign mem_be     = req ? strobe : '0;
    assign mem_lock   = lock;
    assign done       = fin;
    assign illegal    = fin && illegal_q;
    assign misaligned = fin && misal_q;
    assign wb_en      = fin && fetch_q && !illegal_q && !misal_q;
    assign wb_to_r0   = wb_en && (kind_q == K_CAS);
    assign wb_data    = wb_en ? old_val : '0;
endmodule

// File: rtl/amo_rmw_chk.sv
module amo_rmw_chk
    import amo_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic              mem_lock,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [NBYTE-1:0]  mem_be,
    input logic              done,
    input logic              illegal,
    input logic              misaligned,
    input logic              wb_en
);
    // R9
    req_locked_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_lock);

    // R9
    lock_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_lock) |-> done);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R7
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !(illegal && misaligned));

    // R1
    fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (illegal || misaligned) |-> (!wb_en && !mem_req && !mem_lock));

    // R8
    strobe_shape_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_be == 8'hFF || mem_be == 8'h0F || mem_be == 8'hF0));

    // R3
    wb_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> done);
endmodule

bind atomic_rmw_unit amo_rmw_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ready  (mem_ready),
    .mem_lock   (mem_lock),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .done       (done),
    .illegal    (illegal),
    .misaligned (misaligned),
    .wb_en      (wb_en)
);

// File: tb/atomic_rmw_unit_tb_top.sv
module atomic_rmw_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  op_code = '0;
    logic [31:0] imm_val = '0;
    logic [15:0] offset_val = '0;
    logic [63:0] dst_val = '0, src_val = '0, r0_val = '0;
    logic        mem_req, mem_we, mem_ready, mem_lock;
    logic [63:0] mem_addr, mem_wdata, mem_rdata;
    logic [7:0]  mem_be;
    logic        done, illegal, misaligned, wb_en, wb_to_r0;
    logic [63:0] wb_data;

    always #2 clk = ~clk;

    atomic_rmw_unit #(.ADDR_W(64)) dut_i (
        .clk(clk), .rst(rst), .start(start), .op_code(op_code), .imm_val(imm_val),
        .offset_val(offset_val), .dst_val(dst_val), .src_val(src_val), .r0_val(r0_val),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ready(mem_ready), .mem_lock(mem_lock),
        .done(done), .illegal(illegal), .misaligned(misaligned), .wb_en(wb_en),
        .wb_to_r0(wb_to_r0), .wb_data(wb_data)
    );

    // memory model
    logic [63:0] mem [16];
    int lat = 0;
    int wcnt = 0;
    int nrd = 0, nwr = 0;

    assign mem_ready = mem_req && (wcnt >= lat);
    assign mem_rdata = mem[mem_addr[6:3]];

    always @(posedge clk) begin
        if (mem_req && !mem_ready) wcnt <= wcnt + 1;
        else                       wcnt <= 0;
        if (mem_req && mem_ready) begin
            if (mem_we) begin
                nwr = nwr + 1;
                for (int b = 0; b < 8; b++)
                    if (mem_be[b]) mem[mem_addr[6:3]][8*b +: 8] = mem_wdata[8*b +: 8];
            end else begin
                nrd = nrd + 1;
            end
        end
    end

    int checks = 0, fails = 0;
    int lock_bad = 0;
    logic g_illegal, g_misal, g_wb_en, g_wb_r0, g_pulse_ok;
    logic [63:0] g_wb_data;
    logic [63:0] rs = 64'h9E3779B97F4A7C15;

    function automatic logic [63:0] nxt(input logic [63:0] x);
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [7:0] opc, input logic [31:0] imm, input logic [15:0] off,
                          input logic [63:0] d, input logic [63:0] s, input logic [63:0] r);
        int  cyc;
        bit  seen;
        @(negedge clk);
        op_code = opc; imm_val = imm; offset_val = off;
        dst_val = d; src_val = s; r0_val = r;
        start = 1'b1; nrd = 0; nwr = 0; lock_bad = 0; seen = 0;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 1000) begin
            if (mem_req) seen = 1;
            if (seen && !mem_lock) lock_bad++;
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL R10 op timeout actual=%0d expected=<1000", cyc);
        end
        g_illegal = illegal; g_misal = misaligned; g_wb_en = wb_en;
        g_wb_r0 = wb_to_r0; g_wb_data = wb_data;
        @(negedge clk);
        g_pulse_ok = !done;
    endtask

    function automatic void model(input logic [63:0] line, input bit wide, input bit lane,
                                  input logic [7:0] im, input logic [63:0] s, input logic [63:0] r,
                                  output logic [63:0] nl, output int wr, output logic [63:0] oldv);
        logic [63:0] res;
        logic [31:0] oh;
        bit eq;
        oh   = lane ? line[63:32] : line[31:0];
        oldv = wide ? line : {32'h0, oh};
        case (im[7:4])
            4'h0: res = oldv + s;
            4'h4: res = oldv | s;
            4'h5: res = oldv & s;
            4'ha: res = oldv ^ s;
            default: res = s;
        endcase
        eq = wide ? (line == r) : (oh == r[31:0]);
        wr = (im == 8'hf1 && !eq) ? 0 : 1;
        if (wr == 0)   nl = line;
        else if (wide) nl = res;
        else           nl = lane ? {res[31:0], line[31:0]} : {line[63:32], res[31:0]};
    endfunction

    // full legal case with all checks
    task automatic legal_case(input bit wide, input logic [7:0] im, input logic [15:0] off,
                              input logic [63:0] d, input logic [63:0] s, input logic [63:0] r,
                              input logic [63:0] line);
        logic [63:0] a, nl, oldv;
        int  wr;
        string ktag;
        a = d + {{48{off[15]}}, off};
        mem[a[6:3]] = line;
        model(line, wide, a[2], im, s, r, nl, wr, oldv);
        run_op(wide ? 8'hDB : 8'hC3, {24'h0, im}, off, d, s, r);
        ktag = (im == 8'he1) ? "R4" : (im == 8'hf1) ? "R5" : "R2";
        chk(wide ? ktag : "R8", mem[a[6:3]], nl);
        chk("R10 reads", nrd, 1);
        chk((im == 8'hf1) ? "R5 writes" : "R10 writes", nwr, wr);
        chk("R3 wb_en", g_wb_en, im[0]);
        chk((im == 8'hf1) ? "R5 wb_data" : "R3 wb_data", g_wb_data, im[0] ? oldv : 64'h0);
        chk((im == 8'hf1) ? "R5 wb_to_r0" : "R3 wb_to_r0", g_wb_r0, im == 8'hf1);
        chk("R1 flags", {g_illegal, g_misal}, 2'b00);
        chk("R9 lock", lock_bad, 0);
        chk("R10 pulse", g_pulse_ok, 1'b1);
    endtask

    task automatic fault_case(input string tag, input logic [7:0] opc, input logic [31:0] imm,
                              input logic [15:0] off, input logic exp_ill, input logic exp_mis);
        run_op(opc, imm, off, 64'h3000, 64'h5, 64'h7);
        chk(tag, {g_illegal, g_misal}, {exp_ill, exp_mis});
        chk(tag, nrd + nwr, 0);
        chk(tag, g_wb_en, 1'b0);
    endtask

    logic [7:0] imm_list [10] = '{8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51,
                                  8'ha0, 8'ha1, 8'he1, 8'hf1};

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R10 global watchdog actual=expired expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 64'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 done", done, 1'b0);
        chk("R11 mem_req", mem_req, 1'b0);
        chk("R11 mem_lock", mem_lock, 1'b0);
        chk("R11 wb_en", wb_en, 1'b0);

        // sweep over operations, widths, lanes, latencies, compare outcomes
        for (int l = 0; l < 2; l++) begin
            lat = l * 3;
            for (int w = 0; w < 2; w++)
                for (int ln = 0; ln < 2; ln++)
                    for (int k = 0; k < 10; k++)
                        for (int v = 0; v < 2; v++) begin
                            logic [63:0] line, s, r, d;
                            logic [15:0] off;
                            rs = nxt(rs); line = rs;
                            rs = nxt(rs); s = rs;
                            rs = nxt(rs); r = rs;
                            if (v == 1)
                                r = w ? line : (ln ? {r[63:32], line[63:32]} : {r[63:32], line[31:0]});
                            d = 64'h2040 + 64'(k % 8) * 8;
                            off = ln ? (w ? 16'hFFF8 : 16'hFFFC) : 16'h0010;
                            legal_case(w[0], imm_list[k], off, d, s, r, line);
                        end
        end
        lat = 1;

        // R2 wrap-around
        legal_case(1'b1, 8'h00, 16'h0000, 64'h2000, 64'h1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
        legal_case(1'b0, 8'h01, 16'h0000, 64'h2000, 64'hFFFF_FFFF_0000_0002, 64'h0,
                   64'hA5A5_A5A5_FFFF_FFFF);
        // R8 word at offset 4 is aligned, upper lane
        legal_case(1'b0, 8'he1, 16'h0004, 64'h2008, 64'h1234_5678_9ABC_DEF0, 64'h0,
                   64'h1111_2222_3333_4444);

        // R6 immediate sweep
        for (int i = 0; i < 256; i++) begin
            bit ok;
            ok = 0;
            for (int k = 0; k < 10; k++) if (imm_list[k] == i[7:0]) ok = 1;
            run_op(8'hDB, 32'(i), 16'h0000, 64'h3000, 64'h3, 64'h9);
            chk("R6 illegal", g_illegal, !ok);
            if (!ok) chk("R6 no access", nrd + nwr, 0);
        end
        fault_case("R6 high imm bits", 8'hDB, 32'h0000_0100, 16'h0, 1'b1, 1'b0);
        fault_case("R6 high imm bits", 8'hC3, 32'h8000_0041, 16'h0, 1'b1, 1'b0);

        // R1 opcode forms
        fault_case("R1 size half", 8'hCB, 32'h0, 16'h0, 1'b1, 1'b0);
        fault_case("R1 size byte", 8'hD3, 32'h0, 16'h0, 1'b1, 1'b0);
        fault_case("R1 plain mode", 8'h7B, 32'h0, 16'h0, 1'b1, 1'b0);
        fault_case("R1 imm class", 8'hDA, 32'h0, 16'h0, 1'b1, 1'b0);
        fault_case("R1 alu class", 8'hDF, 32'h0, 16'h0, 1'b1, 1'b0);

        // R7 alignment
        for (int o = 1; o < 8; o++)
            fault_case("R7 dword", 8'hDB, 32'h51, 16'(o), 1'b0, 1'b1);
        for (int o = 1; o < 8; o++)
            if (o != 4) fault_case("R7 word", 8'hC3, 32'h41, 16'(o), 1'b0, 1'b1);
        fault_case("R7 precedence", 8'hCB, 32'h0, 16'h1, 1'b1, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule